// File: doc/BRIEF.md
# Flash Command Cycle Sequencer

This block sits on the device side of a behavioural NOR flash model. It watches the host's write cycles and turns recognised address/data patterns into commands for the model's storage and timing logic. These commands are word program, sector erase, erase suspend, erase resume and abort. The block also drives the ready/busy line. After power-up it is in read-array mode, and reads need no command. A write cycle that does not fit the sequence in progress drops the machine back to read-array mode and has no other effect.

Normally a word program takes two unlock cycles, a program code and then the address/data cycle. An unlock-bypass mode cuts this to a code cycle plus the address/data cycle. The host can enter that mode with a command. The accelerate input also forces the mode on for as long as it is held. The embedded operation itself runs outside the block; the model reports its end with a one-cycle done strobe. A reset pin that stays low long enough aborts whatever is running, including a suspended erase. After such an abort, the block holds ready/busy low for a fixed recovery time.

Top module: `flash_cmd_seq`

## Requirements
- R1: After the system reset, `ready` is 1 and `cmd_valid` is 0. The machine is in read-array mode with bypass off and no operation running.
- R2: An unlock cycle compares the low UNLK_W (11) address bits and the low 8 data bits. Writing AAh at 555h, then 55h at 2AAh, then A0h at any address, then an address/data cycle emits `cmd_code` 1 (program) one cycle after the last write. `cmd_addr` and `cmd_data` carry that last cycle's address and data.
- R3: The sequence AAh@555h, 55h@2AAh, 20h@555h enters bypass. In bypass mode, A0h at any address followed by one address/data cycle emits a program. The pair 90h then 00h at any address leaves bypass, after which A0h no longer starts a program.
- R4: While `accel` is 1, the machine acts as if in bypass mode. When `accel` returns to 0, the four-cycle program is needed again unless bypass was entered by command.
- R5: The sequence AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, 30h@sector emits `cmd_code` 2 (erase), with `cmd_addr` set to the sector address.
- R6: `ready` is 0 from the cycle a program or erase command is emitted until the cycle after `op_done`. A program issued while an erase is suspended returns the machine to the suspended state on `op_done`.
- R7: B0h at any address while an erase runs emits `cmd_code` 3 (suspend) and sets `ready` to 1. B0h at any other time emits nothing.
- R8: While an erase is suspended, 30h at any address as a first cycle emits `cmd_code` 4 (resume) and sets `ready` to 0. An erase sequence started while suspended is refused at its 80h cycle.
- R9: A cycle that breaks a sequence returns to read-array mode without a command. Writes while a program, erase or suspended-program runs are ignored, except B0h as in R7.
- R10: When `hw_reset_n` is sampled low on RST_MIN consecutive edges, sequence, bypass and operation are cleared. If an operation, including a suspended erase, was active, `cmd_code` 5 (abort) is emitted after that RST_MIN-th edge. A shorter low pulse has no effect, and writes while the pin is low are ignored.
- R11: After an abort, `ready` stays 0 for exactly RDY_DLY cycles, and writes are ignored during that time. A qualifying reset with no operation active leaves `ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| hw_reset_n | input | 1 | Hardware reset pin, active low, pulse-width qualified |
| accel | input | 1 | Accelerate flag, forces bypass mode while high |
| wr_en | input | 1 | Host write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | DATA_W | Write cycle data |
| op_done | input | 1 | End-of-embedded-operation strobe from the model |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 3 | 1 program, 2 erase, 3 suspend, 4 resume, 5 abort |
| cmd_addr | output | ADDR_W | Program or sector address |
| cmd_data | output | DATA_W | Program data |
| ready | output | 1 | Ready/busy, low while busy |

## Verification
The bench builds the block with RST_MIN = 3 and RDY_DLY = 5. With these values, both the one-edge-short reset pulse and the exact qualifying pulse fit in a few cycles, and the full recovery window can be counted cycle by cycle. UNLK_W stays at 11, and ADDR_W stays at 23. As a result, random addresses only rarely alias an unlock address, and the random phase tests that sequences break cleanly.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W  = 23,
  parameter int DATA_W  = 16,
  parameter int UNLK_W  = 11,
  parameter int RST_MIN = 4,
  parameter int RDY_DLY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_n,
  input  logic              accel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              ready
);
  localparam int CNT_W = $clog2(RST_MIN + 1);
  localparam int RDY_W = $clog2(RDY_DLY + 1);
  localparam logic [UNLK_W-1:0] UA1 = UNLK_W'(12'h555);
  localparam logic [UNLK_W-1:0] UA2 = UNLK_W'(12'h2AA);
  localparam logic [2:0] C_PROG = 3'd1, C_ERASE = 3'd2, C_SUSP = 3'd3,
                         C_RES = 3'd4, C_ABORT = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_UN1, S_UN2, S_PGM, S_ER1, S_ER2, S_ER3, S_BX} seq_t;
  typedef enum logic [2:0] {O_NONE, O_PROG, O_ERASE, O_SUSP, O_SPROG} op_t;

  seq_t seq, seq_n;
  op_t  op, op_n;
  logic byp, byp_n;
  logic [CNT_W-1:0] low_cnt;
  logic [RDY_W-1:0] rdy_cnt;
  logic emit;
  logic [2:0] code_n;

  wire [7:0] cd     = wr_data[7:0];
  wire       at1    = wr_addr[UNLK_W-1:0] == UA1;
  wire       at2    = wr_addr[UNLK_W-1:0] == UA2;
  wire       byp_on = byp | accel;
  wire       wr_ok  = wr_en && hw_reset_n && (rdy_cnt == '0);
  wire       qual   = !hw_reset_n && (low_cnt == CNT_W'(RST_MIN - 1));
  wire       busy   = (op == O_PROG) || (op == O_ERASE) || (op == O_SPROG);

  assign ready = !busy && (rdy_cnt == '0);

  always_comb begin
    seq_n  = seq;
    op_n   = op;
    byp_n  = byp;
    emit   = 1'b0;
    code_n = cmd_code;
    if (op_done) begin
      case (op)
        O_PROG, O_ERASE: op_n = O_NONE;
        O_SPROG:         op_n = O_SUSP;
        default:         op_n = op;
      endcase
    end
    if (wr_ok) begin
      if (busy) begin
        seq_n = S_IDLE;
        if (op == O_ERASE && cd == 8'hB0) begin
          op_n = O_SUSP; emit = 1'b1; code_n = C_SUSP;
        end
      end else begin
        seq_n = S_IDLE;
        unique case (seq)
          S_IDLE: begin
            if (op == O_SUSP && cd == 8'h30) begin
              op_n = O_ERASE; emit = 1'b1; code_n = C_RES;
            end else if (byp_on) begin
              if (cd == 8'hA0)      seq_n = S_PGM;
              else if (cd == 8'h90) seq_n = S_BX;
            end else if (at1 && cd == 8'hAA) seq_n = S_UN1;
          end
          S_UN1: if (at2 && cd == 8'h55) seq_n = S_UN2;
          S_UN2: begin
            if (cd == 8'hA0)                      seq_n = S_PGM;
            else if (cd == 8'h20)                 byp_n = 1'b1;
            else if (cd == 8'h80 && op != O_SUSP) seq_n = S_ER1;
          end
          S_PGM: begin
            op_n = (op == O_SUSP) ? O_SPROG : O_PROG;
            emit = 1'b1; code_n = C_PROG;
          end
          S_ER1: if (at1 && cd == 8'hAA) seq_n = S_ER2;
          S_ER2: if (at2 && cd == 8'h55) seq_n = S_ER3;
          S_ER3: if (cd == 8'h30) begin
            op_n = O_ERASE; emit = 1'b1; code_n = C_ERASE;
          end
          S_BX: if (cd == 8'h00) byp_n = 1'b0;
          default: seq_n = S_IDLE;
        endcase
      end
    end
    if (qual) begin
      seq_n = S_IDLE; byp_n = 1'b0; op_n = O_NONE;
      emit = (op != O_NONE); code_n = C_ABORT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE; op <= O_NONE; byp <= 1'b0;
      low_cnt <= '0; rdy_cnt <= '0;
      cmd_valid <= 1'b0; cmd_code <= '0; cmd_addr <= '0; cmd_data <= '0;
    end else begin
      seq <= seq_n; op <= op_n; byp <= byp_n;
      cmd_valid <= emit;
      if (emit) cmd_code <= code_n;
      if (emit && wr_ok) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
      end
      if (hw_reset_n)                        low_cnt <= '0;
      else if (low_cnt != CNT_W'(RST_MIN))   low_cnt <= low_cnt + 1'b1;
      if (qual && op != O_NONE)              rdy_cnt <= RDY_W'(RDY_DLY);
      else if (rdy_cnt != '0)                rdy_cnt <= rdy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_reset_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       ready
);
  assert_prog_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd1) |-> !ready);
  assert_erase_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd2) |-> !ready);
  assert_suspend_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd3) |-> ready);
  assert_suspend_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd3) |-> $past(!ready));
  assert_resume_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4) |-> !ready);
  assert_abort_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5) |-> $past(!hw_reset_n));
  assert_pin_low_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(!hw_reset_n)) |-> cmd_code == 3'd5);
  assert_abort_recovery_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5) |-> !ready);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ready(ready)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int ADDR_W = 23, DATA_W = 16, RST_MIN = 3, RDY_DLY = 5;

  logic clk = 1'b0, rst_n = 1'b0, hw_reset_n = 1'b1, accel = 1'b0;
  logic wr_en = 1'b0, op_done = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic cmd_valid, ready;
  logic [2:0] cmd_code;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  int checks = 0, errors = 0;
  int m_seq = 0, m_op = 0;
  bit m_byp = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_W(11),
                  .RST_MIN(RST_MIN), .RDY_DLY(RDY_DLY)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .accel(accel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .ready(ready));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int code);
    case (code)
      1: return "R2"; 2: return "R5"; 3: return "R7"; 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit m_ready();
    return (m_op == 0) || (m_op == 3);
  endfunction

  task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int code);
    bit a1, a2, eb;
    logic [7:0] c;
    c = d[7:0]; a1 = a[10:0] == 11'h555; a2 = a[10:0] == 11'h2AA; eb = m_byp | accel;
    code = 0;
    if (m_op == 1 || m_op == 2 || m_op == 4) begin
      m_seq = 0;
      if (m_op == 2 && c == 8'hB0) begin m_op = 3; code = 3; end
      return;
    end
    case (m_seq)
      0: begin
        m_seq = 0;
        if (m_op == 3 && c == 8'h30) begin m_op = 2; code = 4; end
        else if (eb) begin
          if (c == 8'hA0) m_seq = 3; else if (c == 8'h90) m_seq = 7;
        end else if (a1 && c == 8'hAA) m_seq = 1;
      end
      1: m_seq = (a2 && c == 8'h55) ? 2 : 0;
      2: begin
        m_seq = 0;
        if (c == 8'hA0) m_seq = 3;
        else if (c == 8'h20) m_byp = 1'b1;
        else if (c == 8'h80 && m_op != 3) m_seq = 4;
      end
      3: begin m_seq = 0; m_op = (m_op == 3) ? 4 : 1; code = 1; end
      4: m_seq = (a1 && c == 8'hAA) ? 5 : 0;
      5: m_seq = (a2 && c == 8'h55) ? 6 : 0;
      6: begin m_seq = 0; if (c == 8'h30) begin m_op = 2; code = 2; end end
      7: begin m_seq = 0; if (c == 8'h00) m_byp = 1'b0; end
      default: m_seq = 0;
    endcase
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
    int code;
    string t;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d, code);
    t = (tag == "") ? tag_of(code) : tag;
    @(negedge clk);
    wr_en = 1'b0;
    check(cmd_valid == (code != 0), t, cmd_valid, code != 0);
    if (code != 0) check(cmd_code == 3'(code), t, cmd_code, code);
    if (code == 1) begin
      check(cmd_addr == a, t, cmd_addr, a);
      check(cmd_data == d, t, cmd_data, d);
    end
    if (code == 2) check(cmd_addr == a, t, cmd_addr, a);
    check(ready == m_ready(), "R6", ready, m_ready());
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    if (m_op == 1 || m_op == 2) m_op = 0; else if (m_op == 4) m_op = 3;
    @(negedge clk);
    op_done = 1'b0;
    check(ready == m_ready(), "R6", ready, m_ready());
    check(!cmd_valid, "R6", cmd_valid, 0);
  endtask

  task automatic unlock(input string tag);
    do_write(23'h555, 16'h00AA, tag);
    do_write(23'h2AA, 16'h0055, tag);
  endtask

  task automatic pin_low(input int n, input bit abort_exp);
    @(negedge clk);
    hw_reset_n = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (abort_exp && i == RST_MIN) begin
        check(cmd_valid && cmd_code == 3'd5, "R10", {cmd_valid, cmd_code}, 4'hD);
        check(!ready, "R11", ready, 0);
      end else
        check(!cmd_valid, "R10", cmd_valid, 0);
    end
    hw_reset_n = 1'b1;
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int n_low;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", ready, 1);
    check(cmd_valid == 1'b0, "R1", cmd_valid, 0);

    unlock("R2"); do_write(23'h555, 16'h00A0, "R2"); do_write(23'h12345, 16'hBEEF, "R2");
    do_write(23'h555, 16'h00AA, "R9");
    do_write(23'h555, 16'h00B0, "R7");
    done_pulse();

    do_write(23'h555, 16'h00AA, "R9"); do_write(23'h123, 16'h0055, "R9");
    do_write(23'h555, 16'h00A0, "R9"); do_write(23'h1000, 16'h1234, "R9");

    unlock("R3"); do_write(23'h555, 16'h0020, "R3");
    do_write(23'h0, 16'h00A0, "R3"); do_write(23'h200, 16'h5A5A, "R3");
    done_pulse();
    do_write(23'h0, 16'h0090, "R3"); do_write(23'h0, 16'h0000, "R3");
    do_write(23'h0, 16'h00A0, "R3"); do_write(23'h300, 16'h1111, "R3");

    accel = 1'b1;
    do_write(23'h0, 16'h00A0, "R4"); do_write(23'h400, 16'h2222, "R4");
    done_pulse();
    accel = 1'b0;
    do_write(23'h0, 16'h00A0, "R4"); do_write(23'h500, 16'h3333, "R4");

    do_write(23'h0, 16'h00B0, "R7");
    unlock("R5"); do_write(23'h555, 16'h0080, "R5");
    unlock("R5"); do_write(23'h208000, 16'h0030, "R5");
    do_write(23'h0, 16'h00B0, "R7");
    unlock("R8"); do_write(23'h555, 16'h00A0, "R8"); do_write(23'h9, 16'h7777, "R8");
    done_pulse();
    unlock("R8"); do_write(23'h555, 16'h0080, "R8");
    unlock("R8"); do_write(23'h555, 16'h0030, "R8");
    do_write(23'h0, 16'h0030, "R8");
    done_pulse();

    pin_low(RST_MIN - 1, 1'b0);
    unlock("R10"); do_write(23'h555, 16'h00A0, "R10");
    pin_low(RST_MIN - 1, 1'b0);
    do_write(23'h600, 16'h4444, "R10");
    check(!ready, "R10", ready, 0);
    done_pulse();

    @(negedge clk); hw_reset_n = 1'b0; wr_en = 1'b1; wr_addr = 23'h555; wr_data = 16'h00AA;
    @(negedge clk); wr_en = 1'b0; hw_reset_n = 1'b1;
    check(!cmd_valid, "R10", cmd_valid, 0);
    do_write(23'h2AA, 16'h0055, "R10"); do_write(23'h555, 16'h00A0, "R10");
    do_write(23'h700, 16'h5555, "R10");

    unlock("R10"); do_write(23'h555, 16'h0020, "R10");
    do_write(23'h0, 16'h00A0, "R10"); do_write(23'h800, 16'h6666, "R10");
    pin_low(RST_MIN, 1'b1);
    m_seq = 0; m_op = 0; m_byp = 1'b0;
    n_low = 0;
    while (!ready && n_low < 100) begin n_low++; @(negedge clk); end
    check(n_low == RDY_DLY, "R11", n_low, RDY_DLY);
    do_write(23'h0, 16'h00A0, "R10"); do_write(23'h900, 16'h6767, "R10");

    pin_low(RST_MIN + 2, 1'b0);
    check(ready, "R11", ready, 1);

    unlock("R11"); do_write(23'h555, 16'h0080, "R11");
    unlock("R11"); do_write(23'h10000, 16'h0030, "R11");
    do_write(23'h0, 16'h00B0, "R11");
    pin_low(RST_MIN, 1'b1);
    m_seq = 0; m_op = 0; m_byp = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 23'h555; wr_data = 16'h00AA;
    @(negedge clk); wr_en = 1'b0;
    repeat (RDY_DLY) @(negedge clk);
    do_write(23'h2AA, 16'h0055, "R11"); do_write(23'h555, 16'h00A0, "R11");
    do_write(23'hA00, 16'h1357, "R11");

    for (int it = 0; it < 3000; it++) begin
      int r, k;
      logic [ADDR_W-1:0] ra;
      logic [DATA_W-1:0] rd;
      r = $urandom % 16; k = $urandom % 5;
      ra = ADDR_W'($urandom); rd = DATA_W'($urandom);
      if (r == 0) done_pulse();
      else if (r == 1) begin @(negedge clk); accel = ($urandom % 4) == 0; end
      else if (r <= 3) do_write(ra, rd, "");
      else begin
        case (m_seq)
          0: case (k)
               0: do_write(23'h555, 16'h00AA, "");
               1: do_write(ra, 16'h00A0, "");
               2: do_write(ra, 16'h0090, "");
               3: do_write(ra, 16'h00B0, "");
               default: do_write(ra, 16'h0030, "");
             endcase
          1, 5: do_write(23'h2AA, 16'h0055, "");
          2: do_write(23'h555, (k < 2) ? 16'h00A0 : (k < 4) ? 16'h0080 : 16'h0020, "");
          4: do_write(23'h555, 16'h00AA, "");
          6: do_write(ra, 16'h0030, "");
          7: do_write(ra, 16'h0000, "");
          default: do_write(ra, rd, "");
        endcase
      end
    end
    finish_up();
  end
endmodule